// File: doc/BRIEF.md
# Multi-Rail Power-On Reset Sequencer

This block turns a set of per-rail "supply good" flags into a single active-low device reset. Each flag comes from an external voltage detector: one for the core rail, one for the analog rail, and one for each I/O bank that carries configuration pins. Every flag is asynchronous and passes through a two-flop synchronizer before the sequencer uses it. The device reset is held while any flag is low. Once every flag is high, a hold-off delay of programmable length runs. The reset is released when that delay ends.

After power-up, the sequencer keeps watching all rails for a fixed window that opens when the last flag goes good. Any flag loss inside that window starts the sequence again. Once the window has closed, only a loss of the core or analog rail resets the device. That loss pulls the reset low at once, with no clock edge needed, and I/O bank flags are ignored from then on. A static strap selects a short hold-off delay for fast wake-up. A two-bit phase output reports where the sequence stands.

Top module: `rail_por_seq`

## Requirements
- R1: While rst_ni is low, dev_rst_no is low and phase_o reads 0 (waiting for rails).
- R2: While any of the core, analog or I/O flags is low, dev_rst_no stays low and phase_o stays 0, whatever order the flags rise in.
- R3: With fast_boot_i low, dev_rst_no is still low DELAY_CYC+4 rising edges after the last flag goes high and is high after DELAY_CYC+5 edges.
- R4: With fast_boot_i high (held static), FAST_CYC replaces DELAY_CYC in R3.
- R5: phase_o encodes 0 = waiting for rails, 1 = hold-off delay, 2 = watch window with reset released, 3 = user mode. Counting from the edge after the last flag rises, phase_o becomes 1 after 3 edges, 2 after DELAY_CYC+3 edges and 3 after WIN_CYC+3 edges (for WIN_CYC greater than the selected delay).
- R6: After release, a low level on core_ok_i or ana_ok_i drives dev_rst_no low without waiting for a clock edge, and phase_o returns to 0 within 3 edges.
- R7: If an I/O flag drops t rising edges after the last flag went high, with 1 <= t <= WIN_CYC, the sequence restarts: 6 edges later phase_o is 0 and dev_rst_no is low.
- R8: If an I/O flag drops t > WIN_CYC edges after the last flag went high, it has no effect: phase_o stays 3 and dev_rst_no stays high.
- R9: A flag loss during the hold-off delay returns phase_o to 0. When the flag comes back, the full delay of R3 is counted again from that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running always-on clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the sequencer |
| core_ok_i | input | 1 | Core rail good flag, asynchronous |
| ana_ok_i | input | 1 | Analog rail good flag, asynchronous |
| io_ok_i | input | N_IO | Configuration-bank I/O rail good flags, asynchronous |
| fast_boot_i | input | 1 | Static strap selecting the short hold-off delay |
| dev_rst_no | output | 1 | Active-low device reset: asynchronous assert, synchronous release |
| phase_o | output | 2 | Sequence phase code, as defined in R5 |

## Verification
The bench builds the block with DELAY_CYC = 20, FAST_CYC = 5, WIN_CYC = 50 and two I/O banks. With these values the whole power-up sequence takes well under a hundred cycles. That makes it affordable to sweep an I/O flag drop across every cycle offset from 1 to beyond the end of the window, alternating between the two banks. The sweep reaches both sides of the window edge, including the cycle where a drop and the window closing coincide. The same small values let the bench try each rail as the last to rise and time the release edge exactly in both delay modes.

// File: rtl/rail_por_pkg.sv
`timescale 1ns/1ps
package rail_por_pkg;
  typedef enum logic [1:0] {
    PH_WAIT  = 2'd0,
    PH_DELAY = 2'd1,
    PH_WATCH = 2'd2,
    PH_USER  = 2'd3
  } por_phase_e;
endpackage

// File: rtl/rail_sync.sv
`timescale 1ns/1ps
module rail_sync #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic s1, s2;
    // reset value 0: a rail is treated as bad until seen good
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d_i[b];
        s2 <= s1;
      end
    end
    assign q_o[b] = s2;
  end
endmodule

// File: rtl/por_timer.sv
`timescale 1ns/1ps
module por_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (en_i)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/rst_stage.sv
`timescale 1ns/1ps
module rst_stage #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic kill_ni,
  input  logic rel_i,
  output logic rst_no
);
  logic [STAGES-1:0] sh;
  // assert asynchronously, release through STAGES flops
  always_ff @(posedge clk_i or negedge kill_ni) begin
    if (!kill_ni) sh <= '0;
    else          sh <= {sh[STAGES-2:0], rel_i};
  end
  assign rst_no = sh[STAGES-1];
endmodule

// File: rtl/rail_por_seq.sv
`timescale 1ns/1ps
module rail_por_seq
  import rail_por_pkg::*;
#(
  parameter int N_IO      = 2,
  parameter int DELAY_CYC = 250000,
  parameter int FAST_CYC  = 256,
  parameter int WIN_CYC   = 900000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            core_ok_i,
  input  logic            ana_ok_i,
  input  logic [N_IO-1:0] io_ok_i,
  input  logic            fast_boot_i,
  output logic            dev_rst_no,
  output logic [1:0]      phase_o
);
  localparam int N_RAIL  = N_IO + 2;
  localparam int MAX_DF  = (DELAY_CYC > FAST_CYC) ? DELAY_CYC : FAST_CYC;
  localparam int MAX_CYC = (MAX_DF > WIN_CYC) ? MAX_DF : WIN_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int OUT_STG = 2;

  logic [N_RAIL-1:0] ok_s;
  logic              all_ok, brown_ok;
  logic [CNT_W-1:0]  tmr, dly_lim, win_lim;
  logic              tmr_clr, tmr_en;
  por_phase_e        st, nxt;

  rail_sync #(.W(N_RAIL)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({io_ok_i, ana_ok_i, core_ok_i}),
    .q_o   (ok_s)
  );

  assign all_ok   = &ok_s;
  assign brown_ok = ok_s[0] & ok_s[1];

  assign dly_lim = fast_boot_i ? CNT_W'(FAST_CYC - 1) : CNT_W'(DELAY_CYC - 1);
  assign win_lim = CNT_W'(WIN_CYC - 1);

  // one counter times both the hold-off and the I/O watch window
  por_timer #(.W(CNT_W)) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (tmr_clr),
    .en_i  (tmr_en),
    .cnt_o (tmr)
  );

  always_comb begin
    nxt     = st;
    tmr_clr = 1'b0;
    tmr_en  = 1'b0;
    unique case (st)
      PH_WAIT: begin
        tmr_clr = 1'b1;
        if (all_ok) nxt = PH_DELAY;
      end
      PH_DELAY: begin
        tmr_en = 1'b1;
        if (!all_ok)             nxt = PH_WAIT;
        else if (tmr == dly_lim) nxt = (tmr >= win_lim) ? PH_USER : PH_WATCH;
      end
      PH_WATCH: begin
        tmr_en = 1'b1;
        if (!all_ok)             nxt = PH_WAIT;
        else if (tmr == win_lim) nxt = PH_USER;
      end
      PH_USER: begin
        if (!brown_ok) nxt = PH_WAIT;
      end
      default: nxt = PH_WAIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st <= PH_WAIT;
    else         st <= nxt;
  end

  logic rel, kill_n;
  assign rel    = (st == PH_WATCH) || (st == PH_USER);
  // raw core/analog loss clears the output stage without a clock
  assign kill_n = rst_ni & core_ok_i & ana_ok_i;

  rst_stage #(.STAGES(OUT_STG)) u_out (
    .clk_i  (clk_i),
    .kill_ni(kill_n),
    .rel_i  (rel),
    .rst_no (dev_rst_no)
  );

  assign phase_o = st;
endmodule

// File: rtl/rail_por_chk.sv
`timescale 1ns/1ps
module rail_por_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       core_ok_i,
  input logic       ana_ok_i,
  input logic       dev_rst_no,
  input logic [1:0] phase_o
);
  a_r1_reset_low: assert property (@(posedge clk_i)
    !rst_ni |-> !dev_rst_no);

  a_r6_brownout_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!core_ok_i || !ana_ok_i) |-> !dev_rst_no);

  a_r3_release_after_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dev_rst_no) |-> ($past(phase_o, 2) >= 2'd2));

  a_r5_phase_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(phase_o) |-> (phase_o == 2'd0) ||
                          (phase_o == $past(phase_o) + 2'd1) ||
                          (phase_o == 2'd3 && $past(phase_o) == 2'd1));

  a_r8_user_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'd3 && core_ok_i && ana_ok_i && $past(core_ok_i) && $past(ana_ok_i)
     && $past(core_ok_i, 2) && $past(ana_ok_i, 2)) |=> (phase_o == 2'd3));
endmodule

bind rail_por_seq rail_por_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .core_ok_i (core_ok_i),
  .ana_ok_i  (ana_ok_i),
  .dev_rst_no(dev_rst_no),
  .phase_o   (phase_o)
);

// File: tb/rail_por_seq_test.sv
`timescale 1ns/1ps
module rail_por_seq_test;
  localparam int DLY = 20;
  localparam int FST = 5;
  localparam int WIN = 50;
  localparam int NIO = 2;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           core_ok = 1'b0, ana_ok = 1'b0, fast = 1'b0;
  logic [NIO-1:0] io_ok = '0;
  logic           rst_no;
  logic [1:0]     phase;
  int n_chk = 0, n_fail = 0;

  always #10 clk_i = ~clk_i;

  rail_por_seq #(.N_IO(NIO), .DELAY_CYC(DLY), .FAST_CYC(FST), .WIN_CYC(WIN)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .core_ok_i(core_ok), .ana_ok_i(ana_ok),
    .io_ok_i(io_ok), .fast_boot_i(fast), .dev_rst_no(rst_no), .phase_o(phase)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic do_reset(bit f);
    rst_ni = 1'b0; core_ok = 1'b0; ana_ok = 1'b0; io_ok = '0; fast = f;
    step(3);
    chk("R1 reset output", int'(rst_no), 0);
    chk("R1 reset phase", int'(phase), 0);
    rst_ni = 1'b1;
    step(1);
  endtask

  task automatic raise_all();
    core_ok = 1'b1; ana_ok = 1'b1; io_ok = '1;
  endtask

  // release edge: low after lat-1 edges, high after lat
  task automatic rel_check(string req, int lat);
    step(lat - 1);
    chk({req, " still low"}, int'(rst_no), 0);
    step(1);
    chk({req, " released"}, int'(rst_no), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: act=timeout exp=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R2/R3: each rail in turn rises last
    for (int last = 0; last < NIO + 2; last++) begin
      do_reset(1'b0);
      core_ok = (last != 0); ana_ok = (last != 1);
      for (int b = 0; b < NIO; b++) io_ok[b] = (last != b + 2);
      step(7);
      chk("R2 held phase", int'(phase), 0);
      chk("R2 held output", int'(rst_no), 0);
      raise_all();
      rel_check("R3", DLY + 5);
    end

    // R4: fast hold-off
    do_reset(1'b1);
    raise_all();
    rel_check("R4", FST + 5);

    // R5: phase progression
    do_reset(1'b0);
    raise_all();
    step(2);      chk("R5 wait", int'(phase), 0);
    step(1);      chk("R5 delay", int'(phase), 1);
    step(DLY - 1); chk("R5 delay end", int'(phase), 1);
    step(1);      chk("R5 watch", int'(phase), 2);
    step(WIN - DLY - 1); chk("R5 watch end", int'(phase), 2);
    step(1);      chk("R5 user", int'(phase), 3);

    // R6: core loss in user mode
    step(10);
    core_ok = 1'b0;
    #1 chk("R6 core async", int'(rst_no), 0);
    step(3); chk("R6 core phase", int'(phase), 0);
    core_ok = 1'b1;
    rel_check("R6 core recover", DLY + 5);

    // R6: analog loss inside watch window
    do_reset(1'b0);
    raise_all();
    step(DLY + 10);
    chk("R6 pre-drop released", int'(rst_no), 1);
    ana_ok = 1'b0;
    #1 chk("R6 analog async", int'(rst_no), 0);
    step(3); chk("R6 analog phase", int'(phase), 0);
    ana_ok = 1'b1;
    rel_check("R6 analog recover", DLY + 5);

    // R9: loss during hold-off restarts the delay
    do_reset(1'b0);
    raise_all();
    step(8);
    chk("R9 in delay", int'(phase), 1);
    io_ok[1] = 1'b0;
    step(4); chk("R9 io back to wait", int'(phase), 0);
    io_ok[1] = 1'b1;
    rel_check("R9 io restart", DLY + 5);
    do_reset(1'b0);
    raise_all();
    step(12);
    core_ok = 1'b0;
    step(4); chk("R9 core back to wait", int'(phase), 0);
    core_ok = 1'b1;
    rel_check("R9 core restart", DLY + 5);

    // R7/R8: sweep I/O drop offset across the window edge
    for (int t = 1; t <= WIN + 6; t++) begin
      int idx;
      idx = t % NIO;
      do_reset(1'b0);
      raise_all();
      step(t);
      io_ok[idx] = 1'b0;
      step(6);
      if (t <= WIN) begin
        chk("R7 restart phase", int'(phase), 0);
        chk("R7 restart output", int'(rst_no), 0);
      end else begin
        chk("R8 ignored phase", int'(phase), 3);
        chk("R8 ignored output", int'(rst_no), 1);
      end
    end

    // R8: long I/O outage in user mode
    do_reset(1'b0);
    raise_all();
    step(WIN + 10);
    io_ok = '0;
    step(40);
    chk("R8 long outage output", int'(rst_no), 1);
    chk("R8 long outage phase", int'(phase), 3);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule